// File: doc/BRIEF.md
# Sampled Operation Selector with Jitter

This block watches the stream of operations leaving a core pipeline and picks one of them for profiling each time a programmable number of operations has gone by. The counted stream is either architectural instructions or micro-operations, chosen by a configuration bit. The picked operation is flagged with a one-cycle mark in the same cycle its strobe is presented, so downstream capture logic can latch its attributes.

Only one picked operation may be tracked at a time. A busy flag covers the interval from the mark until the pipeline reports that the tracked operation has completed. If another pick comes due while the flag is still up, that pick is thrown away and a saturating collision counter is incremented instead. The counter is incremented before any later record filtering. To keep the picks from locking onto loops whose period matches the interval, a pseudo-random offset drawn from a 16-bit LFSR can be added to each new interval.

Top module: `op_sampler`

## Requirements
- R1: With jitter disabled, the counted operation that completes each run of N counted operations is marked, N being the effective interval; the first mark after reset falls on the Nth counted operation.
- R2: When `cfg_pop_sel` is 0 only `inst_valid` strobes are counted; when it is 1 only `uop_valid` strobes are counted; the other strobe has no effect on marks or on the count.
- R3: The effective interval is the larger of `cfg_interval` and the parameter `MIN_INTERVAL`; a value of 0 (nothing programmed) therefore runs at `MIN_INTERVAL`.
- R4: The LFSR resets to 16'hACE1 and steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}, once at every pick point (marked or dropped). When `cfg_jitter_en` is 1 at that pick point, the low 8 bits of the stepped value are added to the next interval; otherwise nothing is added. The first interval after reset carries no offset.
- R5: `sample_mark` is high only in a cycle with a counted strobe at a pick point while `busy` is low; `busy` is high from the cycle after the mark until the cycle after `done_i` is seen.
- R6: A pick point reached while `busy` is high produces no mark, adds one to `coll_count` and restarts the interval; if `done_i` arrives in that same cycle the pick is still dropped and counted, and `busy` clears.
- R7: `coll_count` (width `COLL_W`) holds at all-ones instead of wrapping.
- R8: `coll_clr` zeroes `coll_count` on the next edge and takes precedence over a collision in the same cycle.
- R9: After reset `sample_mark`, `busy` and `coll_count` are all zero.
- R10: `done_i` while `busy` is low, including in the cycle of a mark, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| inst_valid | input | 1 | One architectural instruction in this cycle |
| uop_valid | input | 1 | One micro-operation in this cycle |
| done_i | input | 1 | The tracked operation has completed |
| cfg_interval | input | INT_W | Programmed pick interval in counted operations |
| cfg_jitter_en | input | 1 | Add LFSR offset to each new interval |
| cfg_pop_sel | input | 1 | 0 counts instructions, 1 counts micro-operations |
| coll_clr | input | 1 | Synchronous clear of the collision counter |
| sample_mark | output | 1 | This cycle's counted operation is picked |
| busy | output | 1 | A picked operation is in flight |
| coll_count | output | COLL_W | Saturating count of dropped picks |

## Verification
The bench keeps an independent model and runs phases aimed at specific corners: intervals programmed below the floor and at zero, where a design without the clamp would pick every one or two operations; a non-selected strobe toggling every cycle, which a wrong mux would count; and completion held off long enough that picks collide until the counter pins at all-ones, where a wrapping counter would fall back to zero. It also lines up a completion with a pick point so that a design which let the completion win would mark instead of counting a collision, and pulses the clear alongside a collision, where the wrong priority leaves a count of one. With jitter enabled the exact mark positions follow the LFSR sequence, so a wrong tap, seed or advance rule moves a mark.

// File: rtl/op_sampler_pkg.sv
package op_sampler_pkg;

    typedef enum logic {
        POP_INST = 1'b0,
        POP_UOP  = 1'b1
    } pop_e;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;  // bits 15,13,12,10
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/op_sampler_lfsr.sv
module op_sampler_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] next_o
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        next_o  = {state_q[W-2:0], ^(state_q & TAPS)};
        state_d = adv ? next_o : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/op_sampler_sat_cnt.sv
module op_sampler_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                        cnt_d = '0;
        else if (inc && (cnt_q != '1))  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/op_sampler_interval.sv
module op_sampler_interval #(
    parameter int INT_W        = 16,
    parameter int JIT_W        = 8,
    parameter int MIN_INTERVAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_cnt,
    input  logic [INT_W-1:0] cfg_interval,
    input  logic             jit_en,
    input  logic [JIT_W-1:0] jit_in,
    output logic             samp_pt
);

    localparam int CW = INT_W + 1;
    localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_INTERVAL);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [JIT_W-1:0] jit;
    } ival_t;

    ival_t s_d, s_q;
    logic [INT_W-1:0] eff;
    logic [CW-1:0]    thr;

    always_comb begin
        eff     = (cfg_interval < MIN_V) ? MIN_V : cfg_interval;
        thr     = CW'(eff) + CW'(s_q.jit);
        samp_pt = op_cnt && ((s_q.cnt + 1'b1) >= thr);
        s_d     = s_q;
        if (samp_pt) begin
            s_d.cnt = '0;
            s_d.jit = jit_en ? jit_in : '0;
        end else if (op_cnt) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/op_sampler.sv
module op_sampler
    import op_sampler_pkg::*;
#(
    parameter int INT_W        = 16,
    parameter int MIN_INTERVAL = 4,
    parameter int JIT_W        = 8,
    parameter int COLL_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_valid,
    input  logic              uop_valid,
    input  logic              done_i,
    input  logic [INT_W-1:0]  cfg_interval,
    input  logic              cfg_jitter_en,
    input  logic              cfg_pop_sel,
    input  logic              coll_clr,
    output logic              sample_mark,
    output logic              busy,
    output logic [COLL_W-1:0] coll_count
);

    typedef struct packed {
        logic busy;
    } trk_t;

    trk_t t_d, t_q;
    pop_e pop;
    logic op_cnt;
    logic samp_pt;
    logic collide;
    logic [LFSR_W-1:0] lfsr_next;

    always_comb begin
        pop         = pop_e'(cfg_pop_sel);
        op_cnt      = (pop == POP_UOP) ? uop_valid : inst_valid;
        sample_mark = samp_pt && !t_q.busy;
        collide     = samp_pt && t_q.busy;
        t_d         = t_q;
        if (sample_mark)  t_d.busy = 1'b1;
        else if (done_i)  t_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;

    op_sampler_interval #(
        .INT_W(INT_W), .JIT_W(JIT_W), .MIN_INTERVAL(MIN_INTERVAL)
    ) u_ival (
        .clk(clk), .rst_n(rst_n), .op_cnt(op_cnt),
        .cfg_interval(cfg_interval), .jit_en(cfg_jitter_en),
        .jit_in(lfsr_next[JIT_W-1:0]), .samp_pt(samp_pt)
    );

    op_sampler_lfsr #(
        .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(samp_pt), .next_o(lfsr_next)
    );

    op_sampler_sat_cnt #(
        .W(COLL_W)
    ) u_coll (
        .clk(clk), .rst_n(rst_n), .clr(coll_clr), .inc(collide),
        .count(coll_count)
    );

endmodule

// File: rtl/op_sampler_chk.sv
module op_sampler_chk #(
    parameter int COLL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inst_valid,
    input logic              uop_valid,
    input logic              cfg_pop_sel,
    input logic              done_i,
    input logic              coll_clr,
    input logic              samp_pt,
    input logic              sample_mark,
    input logic              busy,
    input logic [COLL_W-1:0] coll_count
);

    a_r5_mark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sample_mark |-> !busy);

    a_r5_busy_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
        sample_mark |=> busy);

    a_r5_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done_i) |=> !busy);

    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sample_mark) |=> !busy);

    a_r2_mark_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sample_mark |-> (cfg_pop_sel ? uop_valid : inst_valid));

    a_r6_collision_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_pt && busy && !coll_clr && (coll_count != '1))
        |=> (coll_count == $past(coll_count) + 1'b1));

    a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((coll_count == '1) && !coll_clr) |=> (coll_count == '1));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        coll_clr |=> (coll_count == '0));

endmodule

bind op_sampler op_sampler_chk #(.COLL_W(COLL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .uop_valid(uop_valid),
    .cfg_pop_sel(cfg_pop_sel), .done_i(done_i), .coll_clr(coll_clr),
    .samp_pt(samp_pt), .sample_mark(sample_mark), .busy(busy),
    .coll_count(coll_count)
);

// File: tb/op_sampler_tb.sv
module op_sampler_tb;

    localparam int INT_W  = 16;
    localparam int MINI   = 4;
    localparam int COLL_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inst_valid = 0, uop_valid = 0, done_i = 0, coll_clr = 0;
    logic cfg_jitter_en = 0, cfg_pop_sel = 0;
    logic [INT_W-1:0] cfg_interval = '0;
    logic sample_mark, busy;
    logic [COLL_W-1:0] coll_count;

    always #4 clk = ~clk;

    op_sampler #(.INT_W(INT_W), .MIN_INTERVAL(MINI), .JIT_W(8), .COLL_W(COLL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .uop_valid(uop_valid),
        .done_i(done_i), .cfg_interval(cfg_interval), .cfg_jitter_en(cfg_jitter_en),
        .cfg_pop_sel(cfg_pop_sel), .coll_clr(coll_clr), .sample_mark(sample_mark),
        .busy(busy), .coll_count(coll_count)
    );

    typedef struct {
        bit    mark;
        bit    bsy;
        int    coll;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, marks_seen = 0;

    // staged configuration, applied inside the driver at the next negedge
    int t_int = 0;
    bit t_jit = 0, t_pop = 0;

    // reference state
    int m_cnt = 0, m_jit = 0, m_coll = 0;
    bit m_busy = 0;
    logic [15:0] m_lfsr = 16'hACE1;

    function automatic logic [15:0] lstep(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic step(bit inst, bit uop, bit dn, bit clr, string tag);
        int  eff, thr;
        bit  op, hit;
        exp_t e;
        @(negedge clk);
        inst_valid = inst; uop_valid = uop; done_i = dn; coll_clr = clr;
        cfg_interval = INT_W'(t_int); cfg_jitter_en = t_jit; cfg_pop_sel = t_pop;
        op  = t_pop ? uop : inst;
        eff = (t_int < MINI) ? MINI : t_int;
        thr = eff + m_jit;
        hit = op && (m_cnt + 1 >= thr);
        e.mark = hit && !m_busy; e.bsy = m_busy; e.coll = m_coll; e.tag = tag;
        q.push_back(e);
        if (hit) begin
            m_cnt  = 0;
            m_lfsr = lstep(m_lfsr);
            m_jit  = t_jit ? int'(m_lfsr[7:0]) : 0;
        end else if (op) m_cnt++;
        if (clr) m_coll = 0;
        else if (hit && m_busy && m_coll < 15) m_coll++;
        if (e.mark) m_busy = 1;
        else if (dn) m_busy = 0;
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compares outputs mid-cycle against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(sample_mark == e.mark, e.tag, "sample_mark", int'(sample_mark), int'(e.mark));
                chk(busy == e.bsy, e.tag, "busy", int'(busy), int'(e.bsy));
                chk(int'(coll_count) == e.coll, e.tag, "coll_count", int'(coll_count), e.coll);
                if (sample_mark) marks_seen++;
            end
        end
    end

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: idle after reset
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R9 reset");
        // R1: every 6th instruction, completion a few cycles later
        t_int = 6;
        for (int i = 0; i < 40; i++) step(1, 0, (i % 3) == 2, 0, "R1 interval");
        // R3: below floor, then zero
        t_int = 2;
        for (int i = 0; i < 25; i++) step(1, 0, (i % 2) == 1, 0, "R3 clamp");
        t_int = 0;
        for (int i = 0; i < 25; i++) step((i % 3) != 0, 0, 1, 0, "R3 zero");
        // R2: count micro-ops, instruction strobe always high
        t_int = 5; t_pop = 1;
        for (int i = 0; i < 40; i++) step(1, (i % 2) == 0, (i % 4) == 3, 0, "R2 uop");
        t_pop = 0;
        for (int i = 0; i < 30; i++) step((i % 3) == 1, 1, 1, 0, "R2 inst");
        // R10: completion pulses with nothing tracked
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R10 stray done");
        // R6 / R7: no completion, picks collide until saturation
        t_int = 4;
        for (int i = 0; i < 80; i++) step(1, 0, 0, 0, "R6 R7 collide");
        // R8: clear, then clear together with a collision point
        step(1, 0, 0, 1, "R8 clear");
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0, "R8 after");
        step(1, 0, 0, 1, "R8 clear vs collision");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R8 after");
        // R6: completion in the pick-point cycle still collides
        step(1, 0, 1, 0, "R6 done at pick");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R6 resume");
        step(0, 0, 1, 0, "R6 release");
        // R4: jitter on
        t_jit = 1; t_int = 4;
        for (int i = 0; i < 1500; i++) step((i % 5) != 4, 0, (i % 7) == 0, 0, "R4 jitter");
        t_jit = 0;
        for (int i = 0; i < 600; i++) step(1, 0, 1, 0, "R4 jitter off");
        step(0, 0, 0, 0, "end");
        @(negedge clk); #3;
        chk(marks_seen > 20, "R1", "marks_seen_min", marks_seen, 21);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule